// File: doc/BRIEF.md
# Serial Sampling-Converter Interface and Power-Mode Controller

This block is the digital half of a 12-bit serial sampling converter. A host frames each transfer with an active-low select (`cs_n_i`) and a serial clock (`sclk_i`). The block answers on a serial data line that has a separate drive enable, and a pad cell outside the block does the actual tri-stating. A 12-bit parallel word (`sample_i`) stands in for the analog core. The block captures that word when select falls and then shifts it out, unsigned and most significant bit first, behind a run of zero bits.

The block sees both host inputs through two-flop synchronizers clocked by a faster system clock, and counts serial-clock edges from the last select fall. Where select is released within the frame sets the power mode. Releasing it early in a frame sends the block to shutdown. Releasing it late aborts the word but keeps the block in normal mode. Releasing it before the second edge changes nothing. Leaving shutdown takes a frame that runs past the tenth falling edge. The first frame after power-on, and the first after any shutdown, is flagged invalid. The block also reports the track/hold phase of the sampler.

Two state machines do the work. The frame sequencer has states IDLE, SHIFT and DRAIN: IDLE→SHIFT on a select fall, SHIFT→DRAIN on the 16th falling edge, and SHIFT→IDLE or DRAIN→IDLE on a select rise. The power controller has states NORMAL, SHUTDOWN and WAKING. It goes NORMAL→SHUTDOWN on a select rise after 2 to 9 falling edges, SHUTDOWN→WAKING on a select fall, WAKING→NORMAL on the 10th falling edge, and WAKING→SHUTDOWN on a select rise before that edge.

Top module: `adc_serial_ctrl`

## Requirements
- R1: A falling edge of `cs_n_i` captures `sample_i`, raises `sdo_en_o`, drives `sdo_o` to 0 and raises `hold_o`.
- R2: After the n-th falling edge of `sclk_i` in a frame, `sdo_o` is 0 for n = 1..3 and is captured bit 15−n for n = 4..15 (MSB first, straight binary).
- R3: `sdo_en_o` drops after the 16th falling edge or at the rise of `cs_n_i`, whichever comes first. While `sdo_en_o` is 0, `sdo_o` is 0.
- R4: In normal mode, a rise of `cs_n_i` after fewer than 2 falling edges leaves the mode unchanged.
- R5: In normal mode, a rise of `cs_n_i` after 2 to 9 falling edges sets the mode to shutdown and releases the output.
- R6: In normal mode, a rise of `cs_n_i` after 10 to 15 falling edges keeps normal mode and truncates the word.
- R7: `mode_o` encodes 00 = normal, 01 = shutdown, 10 = waking. From shutdown, a fall of `cs_n_i` gives waking. A rise before the 10th falling edge returns to shutdown. The 10th falling edge with select still low gives normal.
- R8: `result_invalid_o` is loaded at each select fall. It is 1 if no frame has reached its 10th falling edge since reset or since the last entry into shutdown. It reads 1 after reset.
- R9: `hold_o` returns to 0 on the 13th rising edge of `sclk_i`, or at a rise of `cs_n_i` that comes earlier.
- R10: The mode after reset is normal when parameter `START_SHUTDOWN` is 0 and shutdown when it is 1.
- R11: Changes of `sample_i` after the select fall do not alter the word being shifted out.
- R12: Serial-clock edges after the 16th falling edge, while select stays low, leave `sdo_en_o` at 0 and the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low frame select from the host |
| sclk_i | input | 1 | Serial clock from the host |
| sample_i | input | 12 | Parallel sample standing in for the analog core |
| sdo_o | output | 1 | Serial data bit |
| sdo_en_o | output | 1 | Drive enable for the serial data pad |
| hold_o | output | 1 | 1 in hold phase, 0 in track phase |
| mode_o | output | 2 | Power mode: 00 normal, 01 shutdown, 10 waking |
| result_invalid_o | output | 1 | Current frame carries a power-up dummy result |

## Verification
The bench cuts frames after every edge count from 0 to 20 and checks the mode that follows. A wrong bound on the 2..9 window would send the block to shutdown too early or too late, or leave a late abort in shutdown. It runs wake-up frames cut just before and just after the tenth edge. A controller that commits early would report normal after a 9-edge frame, and one that never clears the dummy flag would mark every later result invalid. It also changes the parallel input during every frame and keeps clocking past the 16th edge. That catches a design that shifts out live data or restarts driving inside a finished frame.

// File: rtl/adc_pkg.sv
package adc_pkg;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SHIFT = 2'd1,
        FR_DRAIN = 2'd2
    } frame_st_t;

    typedef enum logic [1:0] {
        PW_NORMAL   = 2'b00,
        PW_SHUTDOWN = 2'b01,
        PW_WAKING   = 2'b10
    } pwr_st_t;

endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int PIPE_W = STAGES + 1;

    logic [PIPE_W-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pipe_q <= {PIPE_W{RESET_VAL}};
        else
            pipe_q <= {pipe_q[PIPE_W-2:0], din};
    end

    // pipe_q[STAGES-1] is the synchronized level, pipe_q[STAGES] its previous value
    assign rise =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall = ~pipe_q[STAGES-1] &  pipe_q[STAGES];
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
    import adc_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int LEAD_ZEROS = 3,
    parameter int CNT_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sclk_fall,
    input  logic              sclk_rise,
    input  logic [DATA_W-1:0] sample,
    output logic              sdo,
    output logic              sdo_en,
    output logic              hold,
    output logic              in_shift,
    output logic [CNT_W-1:0]  fall_cnt
);
    localparam int SHIFT_W     = DATA_W + LEAD_ZEROS;
    localparam int FRAME_FALLS = SHIFT_W + 1;
    localparam int HOLD_RISES  = DATA_W + 1;

    frame_st_t          state_q, state_d;
    logic [SHIFT_W-1:0] shreg_q;
    logic [CNT_W-1:0]   rise_cnt_q;
    logic               last_fall;

    assign last_fall = sclk_fall && (fall_cnt == CNT_W'(FRAME_FALLS - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE:  if (cs_fall) state_d = FR_SHIFT;
            FR_SHIFT: begin
                if (cs_rise)        state_d = FR_IDLE;
                else if (last_fall) state_d = FR_DRAIN;
            end
            FR_DRAIN: if (cs_rise) state_d = FR_IDLE;
            default:  state_d = FR_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            fall_cnt   <= '0;
            rise_cnt_q <= '0;
            sdo        <= 1'b0;
            sdo_en     <= 1'b0;
            hold       <= 1'b0;
        end else begin
            unique case (state_q)
                FR_IDLE: begin
                    if (cs_fall) begin
                        shreg_q    <= {{LEAD_ZEROS{1'b0}}, sample};
                        fall_cnt   <= '0;
                        rise_cnt_q <= '0;
                        sdo        <= 1'b0;
                        sdo_en     <= 1'b1;
                        hold       <= 1'b1;
                    end
                end
                FR_SHIFT, FR_DRAIN: begin
                    if (cs_rise) begin
                        sdo_en <= 1'b0;
                        sdo    <= 1'b0;
                        hold   <= 1'b0;
                    end else begin
                        if (sclk_fall && state_q == FR_SHIFT) begin
                            fall_cnt <= fall_cnt + 1'b1;
                            if (last_fall) begin
                                sdo_en <= 1'b0;
                                sdo    <= 1'b0;
                            end else begin
                                sdo     <= shreg_q[SHIFT_W-1];
                                shreg_q <= {shreg_q[SHIFT_W-2:0], 1'b0};
                            end
                        end
                        if (sclk_rise && rise_cnt_q < CNT_W'(HOLD_RISES)) begin
                            rise_cnt_q <= rise_cnt_q + 1'b1;
                            if (rise_cnt_q == CNT_W'(HOLD_RISES - 1))
                                hold <= 1'b0;
                        end
                    end
                end
                default: begin
                    sdo_en <= 1'b0;
                    sdo    <= 1'b0;
                end
            endcase
        end
    end

    assign in_shift = (state_q == FR_SHIFT);
endmodule

// File: rtl/adc_power_ctl.sv
module adc_power_ctl
    import adc_pkg::*;
#(
    parameter logic START_SHUTDOWN = 1'b0,
    parameter int   ARM_FALL       = 2,
    parameter int   COMMIT_FALL    = 10,
    parameter int   CNT_W          = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             sclk_fall,
    input  logic             in_shift,
    input  logic [CNT_W-1:0] fall_cnt,
    output pwr_st_t          mode,
    output logic             result_invalid
);
    localparam pwr_st_t RESET_MODE = START_SHUTDOWN ? PW_SHUTDOWN : PW_NORMAL;

    pwr_st_t mode_d;
    logic    commit_evt;
    logic    sleep_window;
    logic    pending_q;

    assign commit_evt   = in_shift && sclk_fall && (fall_cnt == CNT_W'(COMMIT_FALL - 1));
    assign sleep_window = (fall_cnt >= CNT_W'(ARM_FALL)) && (fall_cnt < CNT_W'(COMMIT_FALL));

    // next-state logic
    always_comb begin
        mode_d = mode;
        unique case (mode)
            PW_NORMAL:   if (cs_rise && sleep_window) mode_d = PW_SHUTDOWN;
            PW_SHUTDOWN: if (cs_fall) mode_d = PW_WAKING;
            PW_WAKING: begin
                if (cs_rise)         mode_d = PW_SHUTDOWN;
                else if (commit_evt) mode_d = PW_NORMAL;
            end
            default: mode_d = PW_SHUTDOWN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode <= RESET_MODE;
        else        mode <= mode_d;
    end

    // dummy-result bookkeeping and flag output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q      <= 1'b1;
            result_invalid <= 1'b1;
        end else begin
            if (mode_d == PW_SHUTDOWN && mode == PW_NORMAL)
                pending_q <= 1'b1;
            else if (commit_evt)
                pending_q <= 1'b0;
            if (cs_fall)
                result_invalid <= pending_q;
        end
    end
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
    import adc_pkg::*;
#(
    parameter int   DATA_W         = 12,
    parameter int   LEAD_ZEROS     = 3,
    parameter int   SYNC_STAGES    = 2,
    parameter int   ARM_FALL       = 2,
    parameter int   COMMIT_FALL    = 10,
    parameter logic START_SHUTDOWN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              sdo_o,
    output logic              sdo_en_o,
    output logic              hold_o,
    output logic [1:0]        mode_o,
    output logic              result_invalid_o
);
    localparam int FRAME_FALLS = DATA_W + LEAD_ZEROS + 1;
    localparam int CNT_W       = $clog2(FRAME_FALLS + 1);

    logic             cs_fall_w, cs_rise_w;
    logic             sclk_fall_w, sclk_rise_w;
    logic             in_shift_w;
    logic [CNT_W-1:0] fall_cnt_w;
    pwr_st_t          mode_w;

    adc_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cs_n_i),
        .rise (cs_rise_w),
        .fall (cs_fall_w)
    );

    adc_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sclk_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sclk_i),
        .rise (sclk_rise_w),
        .fall (sclk_fall_w)
    );

    adc_frame_seq #(
        .DATA_W    (DATA_W),
        .LEAD_ZEROS(LEAD_ZEROS),
        .CNT_W     (CNT_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_fall  (cs_fall_w),
        .cs_rise  (cs_rise_w),
        .sclk_fall(sclk_fall_w),
        .sclk_rise(sclk_rise_w),
        .sample   (sample_i),
        .sdo      (sdo_o),
        .sdo_en   (sdo_en_o),
        .hold     (hold_o),
        .in_shift (in_shift_w),
        .fall_cnt (fall_cnt_w)
    );

    adc_power_ctl #(
        .START_SHUTDOWN(START_SHUTDOWN),
        .ARM_FALL      (ARM_FALL),
        .COMMIT_FALL   (COMMIT_FALL),
        .CNT_W         (CNT_W)
    ) u_power (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_fall       (cs_fall_w),
        .cs_rise       (cs_rise_w),
        .sclk_fall     (sclk_fall_w),
        .in_shift      (in_shift_w),
        .fall_cnt      (fall_cnt_w),
        .mode          (mode_w),
        .result_invalid(result_invalid_o)
    );

    assign mode_o = mode_w;
endmodule

// File: rtl/adc_serial_ctrl_chk.sv
module adc_serial_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_fall,
    input logic       cs_rise,
    input logic       sclk_rise,
    input logic       sdo_o,
    input logic       sdo_en_o,
    input logic       hold_o,
    input logic [1:0] mode_o,
    input logic       result_invalid_o
);
    p_start_drives_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (sdo_en_o && hold_o && !sdo_o));

    p_release_on_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !sdo_en_o);

    p_quiet_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_en_o |-> !sdo_o);

    p_sleep_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01 && $past(mode_o) == 2'b00) |-> $past(cs_rise));

    p_wake_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == 2'b01) |-> (mode_o != 2'b00));

    p_flag_at_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_invalid_o) |-> $past(cs_fall));

    p_track_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_o) |-> $past(sclk_rise || cs_rise));
endmodule

bind adc_serial_ctrl adc_serial_ctrl_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cs_fall         (cs_fall_w),
    .cs_rise         (cs_rise_w),
    .sclk_rise       (sclk_rise_w),
    .sdo_o           (sdo_o),
    .sdo_en_o        (sdo_en_o),
    .hold_o          (hold_o),
    .mode_o          (mode_o),
    .result_invalid_o(result_invalid_o)
);

// File: tb/sim_adc_serial_ctrl.sv
module sim_adc_serial_ctrl;
    localparam int HALF = 8;
    localparam int MN = 0, MS = 1, MW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic [11:0] sample_i = '0;
    logic        sdo_o, sdo_en_o, hold_o, result_invalid_o;
    logic [1:0]  mode_o;
    logic        sdo1, en1, hold1, inv1;
    logic [1:0]  mode1;

    int checks = 0;
    int errors = 0;
    int mode_m = MN;
    int pend_m = 1;

    always #10 clk = ~clk;

    adc_serial_ctrl #(.START_SHUTDOWN(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sample_i(sample_i),
        .sdo_o(sdo_o), .sdo_en_o(sdo_en_o), .hold_o(hold_o), .mode_o(mode_o),
        .result_invalid_o(result_invalid_o)
    );

    adc_serial_ctrl #(.START_SHUTDOWN(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cs_n_i(1'b1), .sclk_i(1'b1), .sample_i(12'd0),
        .sdo_o(sdo1), .sdo_en_o(en1), .hold_o(hold1), .mode_o(mode1),
        .result_invalid_o(inv1)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_bit(input logic [11:0] smp, input int k);
        if (k <= 3) return 0;
        return int'(smp[15-k]);
    endfunction

    task automatic run_frame(input logic [11:0] smp, input int nf);
        int c;
        sample_i = smp;
        cs_n = 1'b0;
        wait_clk(HALF);
        if (mode_m == MS) mode_m = MW;
        chk("R1 sdo_en at start", int'(sdo_en_o), 1);
        chk("R1 hold at start", int'(hold_o), 1);
        chk("R1 sdo at start", int'(sdo_o), 0);
        chk("R8 invalid flag", int'(result_invalid_o), pend_m);
        chk("R7 mode at start", int'(mode_o), mode_m);
        sample_i = 12'($urandom);  // R11: live input changes mid-frame
        for (int k = 1; k <= nf; k++) begin
            sclk = 1'b0;
            wait_clk(HALF);
            if (k == 10) begin
                mode_m = MN;
                pend_m = 0;
                chk("R7 mode after 10th fall", int'(mode_o), mode_m);
            end
            if (k <= 15) begin
                chk("R2 sdo_en mid-frame", int'(sdo_en_o), 1);
                chk("R2 R11 serial bit", int'(sdo_o), exp_bit(smp, k));
            end else begin
                chk("R3 R12 released after 16th fall", int'(sdo_en_o), 0);
                chk("R12 mode steady", int'(mode_o), mode_m);
            end
            sclk = 1'b1;
            wait_clk(HALF);
            chk("R9 hold phase", int'(hold_o), (k >= 13) ? 0 : 1);
            sample_i = 12'($urandom);
        end
        c = (nf > 16) ? 16 : nf;
        cs_n = 1'b1;
        wait_clk(HALF);
        if (mode_m == MW) mode_m = MS;
        else if (mode_m == MN && c >= 2 && c <= 9) begin
            mode_m = MS;
            pend_m = 1;
        end
        chk("R3 released at cs rise", int'(sdo_en_o), 0);
        chk("R9 track after cs rise", int'(hold_o), 0);
        if (c < 2)       chk("R4 mode after early release", int'(mode_o), mode_m);
        else if (c < 10) chk("R5 R7 mode after mid release", int'(mode_o), mode_m);
        else             chk("R6 mode after late release", int'(mode_o), mode_m);
        wait_clk(HALF);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1234_abcd));
        wait_clk(5);
        chk("R10 reset mode normal", int'(mode_o), MN);
        chk("R10 reset mode shutdown", int'(mode1), MS);
        chk("R3 reset sdo_en", int'(sdo_en_o), 0);
        chk("R9 reset hold", int'(hold_o), 0);
        chk("R8 reset invalid", int'(result_invalid_o), 1);
        rst_n = 1'b1;
        wait_clk(5);
        // directed corner cases
        run_frame(12'hA5C, 16);   // power-on dummy (R8)
        run_frame(12'hFFF, 16);   // valid, all ones
        run_frame(12'h001, 1);    // R4
        run_frame(12'h800, 2);    // R5 lower bound
        run_frame(12'h3C3, 9);    // R7 wake aborted
        run_frame(12'h5A5, 10);   // R7 wake commit
        run_frame(12'h000, 16);   // valid after wake
        run_frame(12'h7E1, 9);    // R5 upper bound
        run_frame(12'h123, 16);   // R7 wake, full frame
        run_frame(12'h456, 12);   // R6
        run_frame(12'h789, 20);   // R12
        run_frame(12'hABC, 0);    // R4 no edges
        for (int i = 0; i < 40; i++)
            run_frame(12'($urandom), int'($urandom_range(0, 20)));
        finish_run();
    end
endmodule